// File: doc/BRIEF.md
# Function-Code Bus Address Decoder

This block sits between a 68000-style processor bus and the on-chip targets behind it. A program ROM, a 256-byte data RAM and two byte-wide character peripherals sit behind it. Each access arrives as a one-cycle request. The request carries an address, a transfer size, a direction, write data and the processor function code. Function-code bit 1 alone decides whether the access is an instruction-space fetch or a data-space access. The address then picks the target inside that space. Requests that would touch memory that does not exist, that would write to program space, or that are misaligned finish with a bus-error pulse and change nothing.

Memory transfers run as 16-bit word cycles. Each word cycle drives active-low upper and lower byte strobes, which select the even and odd byte of the word. A 32-bit transfer takes two word cycles: the second uses the address plus two. Data is big-endian in every case. A peripheral access gives its target a single one-cycle read or write strobe in the request cycle. A read therefore consumes the peripheral's data exactly once. The ROM content is computed from the address, so it needs no storage.

Top module: `bus_fc_decoder`

## Requirements
- R1: After reset, `done` and `berr` are 0, both byte strobes are high, all peripheral strobes are 0, and every RAM byte reads back as 0.
- R2: With `fc[1]`=1 the access reads the ROM, whatever the address. ROM byte at address a is a[7:0] XOR {a[11:8],a[11:8]} XOR 8'h5A. Program space ends at 0xFFF, and any program access that reaches past it raises `berr`, even at a peripheral address.
- R3: A write with `fc[1]`=1 raises `berr`, drives no byte strobe and changes no stored data.
- R4: With `fc[1]`=0, address 0x800000 selects the input peripheral and 0x400000 selects the output peripheral, before any RAM check. The matching read or write strobe is high for the request cycle only. `per_wdata` carries `wdata[7:0]`. A read returns the peripheral byte in `rdata[7:0]` with zeros above it, with `done` one cycle later.
- R5: Any other data-space access goes to RAM at bytes 0x00 to 0xFF. An access whose last byte lies past 0xFF raises `berr` and writes nothing.
- R6: Placement is big-endian. Size code 0 is a byte in `rdata[7:0]` / `wdata[7:0]`. Code 1 is a word in bits 15:0. Code 2 is a long in bits 31:0. The most significant byte is at the lowest address, and unused upper read bits are 0.
- R7: In a word cycle, `uds_n`=0 enables the even byte and `lds_n`=0 enables the odd byte. A byte access at an even address gives `uds_n`=0, `lds_n`=1. At an odd address it gives the reverse. A word or long gives both low.
- R8: A word or long at an odd address raises `berr`. Size code 3 raises `berr`.
- R9: A long memory access takes two word cycles: the request cycle, then one at `cyc_addr` plus 2 with both strobes low. `done` follows two cycles after the request.
- R10: `berr` is a one-cycle pulse, one cycle after the request, never together with `done`. An errored request drives no strobe of any kind.
- R11: Byte, word and peripheral accesses raise `done` for one cycle, one cycle after the request. A write returns `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-cycle access request, taken when idle |
| fc | input | 3 | Processor function code; bit 1 marks program space |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 0 byte, 1 word, 2 long, 3 reserved |
| addr | input | 24 | Byte address of the access |
| wdata | input | 32 | Write data, right-aligned |
| in_rdata | input | 8 | Input peripheral read byte |
| out_rdata | input | 8 | Output peripheral read byte |
| done | output | 1 | Access completed |
| berr | output | 1 | Access rejected with bus error |
| rdata | output | 32 | Read result, right-aligned |
| uds_n | output | 1 | Active-low even-byte strobe of the current word cycle |
| lds_n | output | 1 | Active-low odd-byte strobe of the current word cycle |
| cyc_addr | output | 24 | Address of the current word cycle |
| in_rd_stb | output | 1 | Input peripheral read strobe |
| in_wr_stb | output | 1 | Input peripheral write strobe |
| out_rd_stb | output | 1 | Output peripheral read strobe |
| out_wr_stb | output | 1 | Output peripheral write strobe |
| per_wdata | output | 8 | Byte presented to a peripheral write |

## Verification
The checks assume that `req` is a single-cycle pulse and that no new request arrives until the previous one has answered with `done` or `berr`. They also assume that two erroring requests are never issued on adjacent cycles, since the one-cycle bus-error check relies on that. The stimulus keeps within these rules: one task issues every access, waits for its response, and then idles one more cycle before returning. That extra cycle also lets the bench see that `berr` and `done` fall after one cycle.

// File: rtl/bdec_pkg.sv
package bdec_pkg;

    localparam int ADDR_W    = 24;
    localparam int ROM_BYTES = 4096;
    localparam int RAM_BYTES = 256;
    localparam logic [ADDR_W-1:0] IN_PORT_ADDR  = 24'h800000;
    localparam logic [ADDR_W-1:0] OUT_PORT_ADDR = 24'h400000;
    localparam logic [7:0] ROM_SEED = 8'h5A;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        TGT_NONE = 3'd0,
        TGT_ROM  = 3'd1,
        TGT_RAM  = 3'd2,
        TGT_IN   = 3'd3,
        TGT_OUT  = 3'd4
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    err;
    } route_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SECOND = 1'b1
    } seq_state_e;

    // Offset of the last byte of a transfer relative to its first byte.
    function automatic logic [2:0] last_offset(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd0;
            SZ_WORD: return 3'd1;
            default: return 3'd3;
        endcase
    endfunction

    // Computed program-store content.
    function automatic logic [7:0] rom_byte(input logic [31:0] a, input logic [7:0] seed);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ seed;
    endfunction

endpackage

// File: rtl/bdec_route.sv
module bdec_route
    import bdec_pkg::*;
#(
    parameter int AW        = ADDR_W,
    parameter int ROM_SIZE  = ROM_BYTES,
    parameter int RAM_SIZE  = RAM_BYTES,
    parameter logic [AW-1:0] IN_ADDR  = IN_PORT_ADDR,
    parameter logic [AW-1:0] OUT_ADDR = OUT_PORT_ADDR
) (
    input  logic          prog,
    input  logic          wr,
    input  xfer_size_e    size,
    input  logic [AW-1:0] addr,
    output route_t        route
);
    localparam logic [AW:0] ROM_LIM = ROM_SIZE[AW:0];
    localparam logic [AW:0] RAM_LIM = RAM_SIZE[AW:0];

    logic [AW:0] last_a;
    logic        odd_multi;
    logic        bad_size;

    always_comb begin
        last_a    = {1'b0, addr} + {{(AW-2){1'b0}}, last_offset(size)};
        bad_size  = (size == SZ_RSVD);
        odd_multi = (size != SZ_BYTE) && addr[0];
        route     = '{tgt: TGT_NONE, err: 1'b1};
        if (prog) begin
            route.tgt = TGT_ROM;
            route.err = wr || bad_size || odd_multi || (last_a >= ROM_LIM);
        end else if (addr == IN_ADDR) begin
            route.tgt = TGT_IN;
            route.err = bad_size;
        end else if (addr == OUT_ADDR) begin
            route.tgt = TGT_OUT;
            route.err = bad_size;
        end else begin
            route.tgt = TGT_RAM;
            route.err = bad_size || odd_multi || (last_a >= RAM_LIM);
        end
    end
endmodule

// File: rtl/bdec_rom.sv
module bdec_rom
    import bdec_pkg::*;
#(
    parameter int ROM_SIZE = ROM_BYTES,
    parameter logic [7:0] SEED = ROM_SEED,
    localparam int IDX_W = $clog2(ROM_SIZE)
) (
    input  logic [IDX_W-2:0] word_idx,
    output logic [7:0]       rd_hi,
    output logic [7:0]       rd_lo
);
    logic [31:0] a_even;
    logic [31:0] a_odd;

    always_comb begin
        a_even = 32'({word_idx, 1'b0});
        a_odd  = 32'({word_idx, 1'b1});
        rd_hi  = rom_byte(a_even, SEED);
        rd_lo  = rom_byte(a_odd, SEED);
    end
endmodule

// File: rtl/bdec_ram.sv
module bdec_ram
    import bdec_pkg::*;
#(
    parameter int RAM_SIZE = RAM_BYTES,
    localparam int IDX_W = $clog2(RAM_SIZE)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-2:0] word_idx,
    input  logic             we,
    input  logic             en_hi,
    input  logic             en_lo,
    input  logic [7:0]       wd_hi,
    input  logic [7:0]       wd_lo,
    output logic [7:0]       rd_hi,
    output logic [7:0]       rd_lo
);
    logic [7:0] mem [RAM_SIZE];
    logic [IDX_W-1:0] i_even;
    logic [IDX_W-1:0] i_odd;

    assign i_even = {word_idx, 1'b0};
    assign i_odd  = {word_idx, 1'b1};
    assign rd_hi  = mem[i_even];
    assign rd_lo  = mem[i_odd];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_SIZE; i++) mem[i] <= '0;
        end else if (we) begin
            if (en_hi) mem[i_even] <= wd_hi;
            if (en_lo) mem[i_odd]  <= wd_lo;
        end
    end
endmodule

// File: rtl/bdec_seq.sv
module bdec_seq
    import bdec_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          wr,
    input  xfer_size_e    size,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  route_t        route,
    input  logic [7:0]    per_rd,
    input  logic [7:0]    mem_hi,
    input  logic [7:0]    mem_lo,
    output logic          idle,
    output logic          in_second,
    output logic          cyc_active,
    output target_e       cyc_tgt,
    output logic          cyc_wr,
    output logic [AW-1:0] cyc_addr,
    output logic          lane_hi,
    output logic          lane_lo,
    output logic [7:0]    wd_hi,
    output logic [7:0]    wd_lo,
    output logic          in_rd_stb,
    output logic          in_wr_stb,
    output logic          out_rd_stb,
    output logic          out_wr_stb,
    output logic          done,
    output logic          berr,
    output logic [31:0]   rdata
);
    seq_state_e    st_q;
    logic [AW-1:0] addr_q;
    target_e       tgt_q;
    logic          wr_q;
    logic [15:0]   wlow_q;
    logic [15:0]   hi_q;

    logic          accept;
    logic          accept_ok;
    logic          mem_tgt;
    logic          is_byte;
    logic [15:0]   word_rd;
    logic [15:0]   word_wd;

    always_comb begin
        idle       = (st_q == ST_IDLE);
        in_second  = (st_q == ST_SECOND);
        accept     = idle && req;
        accept_ok  = accept && !route.err;
        mem_tgt    = (route.tgt == TGT_ROM) || (route.tgt == TGT_RAM);
        is_byte    = (size == SZ_BYTE);
        cyc_active = (accept_ok && mem_tgt) || in_second;
        cyc_tgt    = in_second ? tgt_q : route.tgt;
        cyc_wr     = in_second ? wr_q : wr;
        cyc_addr   = in_second ? (addr_q + AW'(2)) : addr;
        lane_hi    = cyc_active && (in_second || !is_byte || !addr[0]);
        lane_lo    = cyc_active && (in_second || !is_byte || addr[0]);
        word_rd    = {mem_hi, mem_lo};
        if (in_second) begin
            word_wd = wlow_q;
        end else begin
            case (size)
                SZ_BYTE: word_wd = {wdata[7:0], wdata[7:0]};
                SZ_WORD: word_wd = wdata[15:0];
                default: word_wd = wdata[31:16];
            endcase
        end
        wd_hi      = word_wd[15:8];
        wd_lo      = word_wd[7:0];
        in_rd_stb  = accept_ok && (route.tgt == TGT_IN)  && !wr;
        in_wr_stb  = accept_ok && (route.tgt == TGT_IN)  &&  wr;
        out_rd_stb = accept_ok && (route.tgt == TGT_OUT) && !wr;
        out_wr_stb = accept_ok && (route.tgt == TGT_OUT) &&  wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            addr_q <= '0;
            tgt_q  <= TGT_NONE;
            wr_q   <= 1'b0;
            wlow_q <= '0;
            hi_q   <= '0;
            done   <= 1'b0;
            berr   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            berr <= 1'b0;
            if (in_second) begin
                st_q  <= ST_IDLE;
                done  <= 1'b1;
                rdata <= wr_q ? 32'd0 : {hi_q, word_rd};
            end else if (accept) begin
                if (route.err) begin
                    berr <= 1'b1;
                end else if (!mem_tgt) begin
                    done  <= 1'b1;
                    rdata <= wr ? 32'd0 : {24'd0, per_rd};
                end else if (size == SZ_LONG) begin
                    st_q   <= ST_SECOND;
                    addr_q <= addr;
                    tgt_q  <= route.tgt;
                    wr_q   <= wr;
                    wlow_q <= wdata[15:0];
                    hi_q   <= word_rd;
                end else begin
                    done <= 1'b1;
                    if (wr)           rdata <= 32'd0;
                    else if (is_byte) rdata <= {24'd0, addr[0] ? mem_lo : mem_hi};
                    else              rdata <= {16'd0, word_rd};
                end
            end
        end
    end
endmodule

// File: rtl/bus_fc_decoder.sv
module bus_fc_decoder
    import bdec_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int ROM_SIZE = ROM_BYTES,
    parameter int RAM_SIZE = RAM_BYTES,
    parameter logic [AW-1:0] IN_ADDR  = IN_PORT_ADDR,
    parameter logic [AW-1:0] OUT_ADDR = OUT_PORT_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [2:0]    fc,
    input  logic          wr,
    input  logic [1:0]    size,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    input  logic [7:0]    in_rdata,
    input  logic [7:0]    out_rdata,
    output logic          done,
    output logic          berr,
    output logic [31:0]   rdata,
    output logic          uds_n,
    output logic          lds_n,
    output logic [AW-1:0] cyc_addr,
    output logic          in_rd_stb,
    output logic          in_wr_stb,
    output logic          out_rd_stb,
    output logic          out_wr_stb,
    output logic [7:0]    per_wdata
);
    localparam int ROM_IW = $clog2(ROM_SIZE);
    localparam int RAM_IW = $clog2(RAM_SIZE);

    xfer_size_e size_e;
    route_t     route;
    target_e    cyc_tgt;
    logic       idle, in_second, cyc_active, cyc_wr;
    logic       lane_hi, lane_lo, ram_we;
    logic [7:0] wd_hi, wd_lo;
    logic [7:0] rom_hi, rom_lo, ram_hi, ram_lo;
    logic [7:0] mem_hi, mem_lo, per_rd;

    assign size_e    = xfer_size_e'(size);
    assign per_rd    = (route.tgt == TGT_IN) ? in_rdata : out_rdata;
    assign mem_hi    = (cyc_tgt == TGT_ROM) ? rom_hi : ram_hi;
    assign mem_lo    = (cyc_tgt == TGT_ROM) ? rom_lo : ram_lo;
    assign ram_we    = cyc_active && cyc_wr && (cyc_tgt == TGT_RAM);
    assign uds_n     = !lane_hi;
    assign lds_n     = !lane_lo;
    assign per_wdata = wdata[7:0];

    bdec_route #(.AW(AW), .ROM_SIZE(ROM_SIZE), .RAM_SIZE(RAM_SIZE),
                 .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR)) i_route (
        .prog (fc[1]),
        .wr   (wr),
        .size (size_e),
        .addr (addr),
        .route(route)
    );

    bdec_rom #(.ROM_SIZE(ROM_SIZE), .SEED(ROM_SEED)) i_rom (
        .word_idx(cyc_addr[ROM_IW-1:1]),
        .rd_hi   (rom_hi),
        .rd_lo   (rom_lo)
    );

    bdec_ram #(.RAM_SIZE(RAM_SIZE)) i_ram (
        .clk     (clk),
        .rst     (rst),
        .word_idx(cyc_addr[RAM_IW-1:1]),
        .we      (ram_we),
        .en_hi   (lane_hi),
        .en_lo   (lane_lo),
        .wd_hi   (wd_hi),
        .wd_lo   (wd_lo),
        .rd_hi   (ram_hi),
        .rd_lo   (ram_lo)
    );

    bdec_seq #(.AW(AW)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .wr        (wr),
        .size      (size_e),
        .addr      (addr),
        .wdata     (wdata),
        .route     (route),
        .per_rd    (per_rd),
        .mem_hi    (mem_hi),
        .mem_lo    (mem_lo),
        .idle      (idle),
        .in_second (in_second),
        .cyc_active(cyc_active),
        .cyc_tgt   (cyc_tgt),
        .cyc_wr    (cyc_wr),
        .cyc_addr  (cyc_addr),
        .lane_hi   (lane_hi),
        .lane_lo   (lane_lo),
        .wd_hi     (wd_hi),
        .wd_lo     (wd_lo),
        .in_rd_stb (in_rd_stb),
        .in_wr_stb (in_wr_stb),
        .out_rd_stb(out_rd_stb),
        .out_wr_stb(out_wr_stb),
        .done      (done),
        .berr      (berr),
        .rdata     (rdata)
    );
endmodule

// File: rtl/bdec_checker.sv
module bdec_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          req,
    input logic          prog,
    input logic          wr,
    input logic          idle,
    input logic          in_second,
    input logic          uds_n,
    input logic          lds_n,
    input logic [AW-1:0] cyc_addr,
    input logic          done,
    input logic          berr,
    input logic          in_rd_stb,
    input logic          in_wr_stb,
    input logic          out_rd_stb,
    input logic          out_wr_stb
);
    logic any_stb;
    assign any_stb = in_rd_stb || in_wr_stb || out_rd_stb || out_wr_stb;

    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(done && berr)); // R10
    AST_BERR_SINGLE: assert property (@(posedge clk) disable iff (rst) berr |=> !berr); // R10
    AST_PROG_WRITE_ERR: assert property (@(posedge clk) disable iff (rst) (req && idle && prog && wr) |=> berr); // R3
    AST_PROG_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst) (req && idle && prog && wr) |-> (uds_n && lds_n && !any_stb)); // R3
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0({in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb})); // R4
    AST_PERIPH_DONE: assert property (@(posedge clk) disable iff (rst) any_stb |=> done); // R4
    AST_LONG_STEP: assert property (@(posedge clk) disable iff (rst) in_second |-> (cyc_addr == $past(cyc_addr) + AW'(2))); // R9
    AST_LONG_LANES: assert property (@(posedge clk) disable iff (rst) in_second |-> (!uds_n && !lds_n)); // R9
    AST_LONG_FINISH: assert property (@(posedge clk) disable iff (rst) in_second |=> (done && !in_second)); // R9
endmodule

bind bus_fc_decoder bdec_checker #(.AW(AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .prog      (fc[1]),
    .wr        (wr),
    .idle      (idle),
    .in_second (in_second),
    .uds_n     (uds_n),
    .lds_n     (lds_n),
    .cyc_addr  (cyc_addr),
    .done      (done),
    .berr      (berr),
    .in_rd_stb (in_rd_stb),
    .in_wr_stb (in_wr_stb),
    .out_rd_stb(out_rd_stb),
    .out_wr_stb(out_wr_stb)
);

// File: tb/test_bus_fc_decoder.sv
module test_bus_fc_decoder;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] IN_BYTE  = 8'hC3;
    localparam logic [7:0] OUT_BYTE = 8'h3C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  fc = 3'b001;
    logic        wr = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        done, berr, uds_n, lds_n;
    logic [31:0] rdata;
    logic [23:0] cyc_addr;
    logic        in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb;
    logic [7:0]  per_wdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;
    logic [7:0] ram_model [256];

    typedef struct {
        bit          err;
        logic [31:0] rd;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_fc_decoder i_bus_fc_decoder (
        .clk(clk), .rst(rst), .req(req), .fc(fc), .wr(wr), .size(size),
        .addr(addr), .wdata(wdata), .in_rdata(IN_BYTE), .out_rdata(OUT_BYTE),
        .done(done), .berr(berr), .rdata(rdata), .uds_n(uds_n), .lds_n(lds_n),
        .cyc_addr(cyc_addr), .in_rd_stb(in_rd_stb), .in_wr_stb(in_wr_stb),
        .out_rd_stb(out_rd_stb), .out_wr_stb(out_wr_stb), .per_wdata(per_wdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_ref(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    // Monitor: pop the expected response whenever the design answers.
    always @(negedge clk) begin
        if (!rst && (done || berr)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10 unexpected response", {30'd0, done, berr}, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(berr == e.err && done == !e.err, {e.tag, " response kind"}, {31'd0, berr}, {31'd0, e.err});
                if (!e.err) chk(rdata == e.rd, {e.tag, " rdata"}, rdata, e.rd);
            end
        end
    end

    // Driver: computes the expected outcome from the requirements and issues one access.
    task automatic access(input bit prog, input bit w, input logic [1:0] sz,
                          input logic [23:0] a, input logic [31:0] d, input string tag);
        int n;
        bit per_in, per_out, err;
        logic [31:0] exp_rd;
        logic [24:0] last;
        bit eu, el;
        int lat;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        per_in  = !prog && (a == 24'h800000);
        per_out = !prog && (a == 24'h400000);
        last = {1'b0, a} + 25'(n - 1);
        if (sz == 2'd3) err = 1'b1;
        else if (prog) err = w || (n > 1 && a[0]) || (last > 25'hFFF);
        else if (per_in || per_out) err = 1'b0;
        else err = (n > 1 && a[0]) || (last > 25'hFF);
        exp_rd = '0;
        if (!err && !w) begin
            if (per_in) exp_rd = {24'd0, IN_BYTE};
            else if (per_out) exp_rd = {24'd0, OUT_BYTE};
            else for (int i = 0; i < n; i++)
                exp_rd = (exp_rd << 8) | 32'(prog ? rom_ref(a + 24'(i)) : ram_model[8'(a + 24'(i))]);
        end
        if (!err && w && !per_in && !per_out)
            for (int i = 0; i < n; i++) ram_model[8'(a + 24'(i))] = 8'(d >> (8 * (n - 1 - i)));
        sb.push_back('{err: err, rd: exp_rd, tag: tag});
        eu = !(err || per_in || per_out) && (n > 1 || !a[0]);
        el = !(err || per_in || per_out) && (n > 1 || a[0]);

        @(negedge clk);
        fc = prog ? 3'b110 : 3'b001; wr = w; size = sz; addr = a; wdata = d; req = 1'b1;
        #1;
        chk(uds_n == !eu && lds_n == !el, {tag, " R7 strobes"}, {30'd0, uds_n, lds_n}, {30'd0, !eu, !el});
        chk({in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb} ==
            {per_in && !w && !err, per_in && w && !err, per_out && !w && !err, per_out && w && !err},
            {tag, " R4 peripheral strobes"}, {28'd0, in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb}, 32'd0);
        if ((per_in || per_out) && w) chk(per_wdata == d[7:0], {tag, " R4 per_wdata"}, {24'd0, per_wdata}, {24'd0, d[7:0]});
        lat = 0;
        do begin
            @(negedge clk);
            req = 1'b0;
            #1;
            lat++;
            if (lat == 1 && n == 4 && !err && !per_in && !per_out) begin
                chk(cyc_addr == a + 24'd2 && !uds_n && !lds_n, {tag, " R9 second word cycle"}, {8'd0, cyc_addr}, {8'd0, a + 24'd2});
                chk({in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb} == 4'd0, {tag, " R4 strobe one cycle"}, 32'd0, 32'd0);
            end
        end while (!(done || berr) && lat < 5);
        chk(lat == ((n == 4 && !err && !per_in && !per_out) ? 2 : 1), {tag, " R11 R9 latency"}, 32'(lat), 32'd0);
        @(negedge clk);
        #1;
        chk(!done && !berr, {tag, " R10 single-cycle response"}, {30'd0, done, berr}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ram_model[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!done && !berr && uds_n && lds_n, "R1 reset outputs", {30'd0, done, berr}, 32'd0);
        chk({in_rd_stb, in_wr_stb, out_rd_stb, out_wr_stb} == 4'd0, "R1 reset strobes", 32'd0, 32'd0);
        access(1'b0, 1'b0, 2'd2, 24'h80, 32'h0, "R1 RAM cleared");
        // R6 R7 RAM placement
        access(1'b0, 1'b1, 2'd1, 24'h10, 32'h0000BEEF, "R6 word write");
        access(1'b0, 1'b0, 2'd0, 24'h10, 32'h0, "R6 even byte read");
        access(1'b0, 1'b0, 2'd0, 24'h11, 32'h0, "R6 odd byte read");
        access(1'b0, 1'b1, 2'd0, 24'h21, 32'h00000077, "R7 odd byte write");
        access(1'b0, 1'b1, 2'd0, 24'h20, 32'h000000A5, "R7 even byte write");
        access(1'b0, 1'b0, 2'd1, 24'h20, 32'h0, "R6 word read back");
        // R9 long split
        access(1'b0, 1'b1, 2'd2, 24'h40, 32'h01234567, "R9 long write");
        access(1'b0, 1'b0, 2'd2, 24'h40, 32'h0, "R9 long read");
        access(1'b0, 1'b0, 2'd0, 24'h43, 32'h0, "R6 long lowest byte");
        access(1'b0, 1'b0, 2'd1, 24'h42, 32'h0, "R6 long low word");
        // R2 program space
        access(1'b1, 1'b0, 2'd0, 24'h000, 32'h0, "R2 ROM byte 0");
        access(1'b1, 1'b0, 2'd1, 24'h123 & 24'hFFE, 32'h0, "R2 ROM word");
        access(1'b1, 1'b0, 2'd2, 24'hFFC, 32'h0, "R2 ROM top long");
        access(1'b1, 1'b0, 2'd0, 24'hFFF, 32'h0, "R2 ROM last byte");
        access(1'b1, 1'b0, 2'd2, 24'hFFE, 32'h0, "R2 ROM long overrun");
        access(1'b1, 1'b0, 2'd0, 24'h800000, 32'h0, "R2 program at peripheral address");
        access(1'b1, 1'b0, 2'd0, 24'h1000, 32'h0, "R2 program past top");
        // R3 program writes
        access(1'b1, 1'b1, 2'd1, 24'h10, 32'h00001111, "R3 program write");
        access(1'b0, 1'b0, 2'd1, 24'h10, 32'h0, "R3 data untouched");
        access(1'b1, 1'b0, 2'd1, 24'h10, 32'h0, "R3 ROM unchanged");
        // R4 peripherals
        access(1'b0, 1'b0, 2'd0, 24'h800000, 32'h0, "R4 input read");
        access(1'b0, 1'b0, 2'd1, 24'h400000, 32'h0, "R4 output read");
        access(1'b0, 1'b1, 2'd0, 24'h400000, 32'h00000041, "R4 output write");
        access(1'b0, 1'b1, 2'd0, 24'h800000, 32'h0000005E, "R4 input write");
        access(1'b0, 1'b0, 2'd0, 24'h800001, 32'h0, "R5 near peripheral address");
        // R5 RAM range
        access(1'b0, 1'b1, 2'd1, 24'hFE, 32'h0000CAFE, "R5 top word write");
        access(1'b0, 1'b0, 2'd0, 24'hFF, 32'h0, "R5 last byte");
        access(1'b0, 1'b1, 2'd2, 24'hFE, 32'hDEADBEEF, "R5 long overrun write");
        access(1'b0, 1'b0, 2'd1, 24'hFE, 32'h0, "R5 no partial write");
        access(1'b0, 1'b0, 2'd0, 24'h100, 32'h0, "R5 byte past RAM");
        // R8 alignment and size
        access(1'b0, 1'b0, 2'd1, 24'h11, 32'h0, "R8 odd word");
        access(1'b0, 1'b1, 2'd2, 24'h41, 32'h0, "R8 odd long write");
        access(1'b0, 1'b0, 2'd2, 24'h40, 32'h0, "R8 long unchanged");
        access(1'b0, 1'b0, 2'd3, 24'h10, 32'h0, "R8 reserved size");
        access(1'b1, 1'b0, 2'd1, 24'h201, 32'h0, "R8 odd program word");
        // R11 write returns zero
        access(1'b0, 1'b1, 2'd0, 24'h30, 32'h0000009C, "R11 write response");
        access(1'b0, 1'b0, 2'd0, 24'h30, 32'h0, "R11 byte zero-extended");
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R10 all responses seen", 32'(sb.size()), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule